// File: doc/BRIEF.md
# GPIO Bank with Routed Pin Interrupts

This block is a bank of general-purpose I/O pins grouped into ports, where each port holds its own number of pins up to a common maximum. Every pin can be driven as an output or read as an input. Every pin can also raise an interrupt on a rising edge, a falling edge, a high level or a low level, and the pin's sense can be inverted first. The whole bank forms one port set. That set has several interrupt outputs, and a per-pin route field chooses which output the pin feeds. Each output can then go to a different processor, and each processor reads only its own output's status word.

Software uses a simple word-addressed bus with a combinational read path and single-cycle writes. Port `p` owns eight words starting at word address `8*p`. Offset 0 is the direction (1 = drive), offset 1 the output value, offset 2 the synchronized input (read-only), offset 3 the interrupt enable, offset 4 the polarity, offset 5 the trigger field (4 bits per pin at bits `4*i+3:4*i`), offset 6 the route field (`RW` bits per pin at bits `RW*i+RW-1:RW*i`, with `RW = clog2(NUM_OUTS)`), and offset 7 the raw pending status. Pending edge bits are cleared by writing 1 to them. Word `8*NUM_PORTS + o` reports interrupt output `o`. Pin `i` of port `p` appears as global bit `p*MAXP + i` on the pin buses and in the per-output words.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every configuration register reads 0, all interrupt outputs are low, and `gpio_oe` and `gpio_out` are all 0.
- R2: A 1 in the direction word (offset 0) sets the matching `gpio_oe` bit. The output-value word (offset 1) appears on `gpio_out`.
- R3: Offset 2 returns `gpio_in` after a two-flop synchronizer, so a new input value is visible two clock edges after it is applied.
- R4: Pins above a port's implemented count read back 0 in every register, never drive `gpio_oe` or `gpio_out`, and ignore writes.
- R5: Trigger bit 0 latches a pending bit on a rising edge and bit 1 on a falling edge of the pin's effective value. The pending bit then stays set after the pin returns.
- R6: Trigger bit 2 makes the pin pending while its effective value is high, and bit 3 while it is low. The pending bit drops as soon as the condition ends.
- R7: Interrupt output `o` is the registered OR of all enabled pending pins whose route field equals `o`. A pin routed to one output never raises another.
- R8: Writing 1 to a bit at offset 7 clears that pin's latched edge pending. The interrupt output falls one cycle later unless another pin still drives it.
- R9: A pin whose enable bit (offset 3) is 0 never raises an interrupt output, but its raw pending bit at offset 7 still reports the event.
- R10: A polarity bit of 1 (offset 4) inverts the pin before edge and level detection.
- R11: Word `8*NUM_PORTS + o` shows, at bit `p*MAXP + i`, whether that pin is enabled, pending and routed to output `o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| gpio_in | input | NUM_PORTS*MAXP | Pin input levels, asynchronous |
| gpio_out | output | NUM_PORTS*MAXP | Pin output values |
| gpio_oe | output | NUM_PORTS*MAXP | Pin output enables |
| irq | output | NUM_OUTS | Routed interrupt outputs |

## Verification
A pin change applied between clock edges reaches the synchronized value on the second edge. A level interrupt appears on `irq` after the third edge. An edge interrupt is latched on the third edge and appears on `irq` after the fourth. A status clear or an enable write acts on the write edge and moves `irq` one edge later. The bench drives all inputs on falling edges and reads outputs just before the next falling edge. It waits five cycles after each pin change and two cycles after each register write, so every result has settled before it is sampled. Before a trigger is armed, the bench moves each pin to its idle level so that no stale edge is latched.

// File: rtl/gir_pkg.sv
package gir_pkg;
   localparam int TRIG_W = 4;
   localparam int TB_RISE = 0;
   localparam int TB_FALL = 1;
   localparam int TB_HIGH = 2;
   localparam int TB_LOW  = 3;

   typedef enum logic [2:0] {
      OFF_DIR   = 3'd0,
      OFF_OUT   = 3'd1,
      OFF_IN    = 3'd2,
      OFF_IE    = 3'd3,
      OFF_POL   = 3'd4,
      OFF_TRIG  = 3'd5,
      OFF_ROUTE = 3'd6,
      OFF_STAT  = 3'd7
   } reg_off_e;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q;
   logic [W-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= d_i;
         sync_q <= meta_q;
      end
   end

   assign q_o = sync_q;
endmodule

// File: rtl/gir_pin_detect.sv
module gir_pin_detect import gir_pkg::*; #(
   parameter int MAXP  = 8,
   parameter int NPINS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [MAXP-1:0]        sync_i,
   input  logic [MAXP-1:0]        pol_i,
   input  logic [TRIG_W*MAXP-1:0] trig_i,
   input  logic [MAXP-1:0]        clr_i,
   output logic [MAXP-1:0]        pend_o
);
   if (NPINS < 1 || NPINS > MAXP) begin : g_chk_pins
      $error("gir_pin_detect: NPINS must lie in 1..MAXP");
   end

   for (genvar i = 0; i < MAXP; i++) begin : g_pin
      if (i < NPINS) begin : g_live
         logic              eff_w, eff_q, sticky_q, set_w, lvl_w;
         logic [TRIG_W-1:0] tr_w;

         assign tr_w  = trig_i[i*TRIG_W +: TRIG_W];
         assign eff_w = sync_i[i] ^ pol_i[i];
         assign set_w = (tr_w[TB_RISE] &  eff_w & ~eff_q)
                      | (tr_w[TB_FALL] & ~eff_w &  eff_q);
         assign lvl_w = (tr_w[TB_HIGH] & eff_w) | (tr_w[TB_LOW] & ~eff_w);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eff_q    <= 1'b0;
               sticky_q <= 1'b0;
            end else begin
               eff_q    <= eff_w;
               sticky_q <= set_w | (sticky_q & ~clr_i[i]);
            end
         end

         assign pend_o[i] = sticky_q | lvl_w;

         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q && !clr_i[i]) |=> sticky_q); // R5
         AST_EDGE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sticky_q) |-> $past(tr_w[TB_RISE] | tr_w[TB_FALL])); // R5
         AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_w) |=> !sticky_q); // R8
         AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ((tr_w == 4'b0100) && (sync_i[i] != pol_i[i])) |-> pend_o[i]); // R6
      end else begin : g_tie
         assign pend_o[i] = 1'b0;
      end
   end

   logic unused_detect;
   assign unused_detect = ^{sync_i, pol_i, trig_i, clr_i};
endmodule

// File: rtl/gir_route.sv
module gir_route #(
   parameter int NPIN = 16,
   parameter int NOUT = 4,
   parameter int RW   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NPIN-1:0]                 pend_i,
   input  logic [NPIN-1:0]                 ie_i,
   input  logic [NPIN*RW-1:0]              route_i,
   output logic [NOUT-1:0][NPIN-1:0]       hit_o,
   output logic [NOUT-1:0]                 irq_o
);
   logic [NOUT-1:0] irq_q;

   for (genvar o = 0; o < NOUT; o++) begin : g_out
      for (genvar j = 0; j < NPIN; j++) begin : g_pin
         assign hit_o[o][j] = pend_i[j] & ie_i[j] & (route_i[j*RW +: RW] == RW'(o));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[o] <= 1'b0;
         else        irq_q[o] <= |hit_o[o];
      end
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router import gir_pkg::*; #(
   parameter int NUM_PORTS = 2,
   parameter int MAXP      = 8,
   parameter logic [NUM_PORTS*4-1:0] PORT_PINS = 8'h58,
   parameter int NUM_OUTS  = 4,
   parameter int DW        = 32,
   parameter int AW        = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW-1:0]             bus_addr,
   input  logic                      bus_wen,
   input  logic [DW-1:0]             bus_wdata,
   output logic [DW-1:0]             bus_rdata,
   input  logic [NUM_PORTS*MAXP-1:0] gpio_in,
   output logic [NUM_PORTS*MAXP-1:0] gpio_out,
   output logic [NUM_PORTS*MAXP-1:0] gpio_oe,
   output logic [NUM_OUTS-1:0]       irq
);
   localparam int NPIN     = NUM_PORTS * MAXP;
   localparam int RW       = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;
   localparam int OUT_BASE = NUM_PORTS * 8;
   localparam int PAW      = AW - 3;

   if (TRIG_W * MAXP > DW) begin : g_chk_trig
      $error("gpio_irq_router: trigger word wider than DW");
   end
   if (RW * MAXP > DW) begin : g_chk_route
      $error("gpio_irq_router: route word wider than DW");
   end
   if (NPIN > DW) begin : g_chk_npin
      $error("gpio_irq_router: per-output status wider than DW");
   end
   if (OUT_BASE + NUM_OUTS > (1 << AW)) begin : g_chk_addr
      $error("gpio_irq_router: address space too small");
   end
   if (MAXP > 15 || NUM_OUTS < 1 || AW < 4) begin : g_chk_misc
      $error("gpio_irq_router: parameter out of range");
   end

   function automatic logic [MAXP-1:0] pin_mask(input int p);
      logic [MAXP-1:0] m;
      int n;
      n = int'(PORT_PINS[p*4 +: 4]);
      for (int i = 0; i < MAXP; i++) m[i] = (i < n);
      return m;
   endfunction

   function automatic logic [TRIG_W*MAXP-1:0] widen_trig(input logic [MAXP-1:0] m);
      logic [TRIG_W*MAXP-1:0] r;
      for (int i = 0; i < MAXP; i++) r[i*TRIG_W +: TRIG_W] = {TRIG_W{m[i]}};
      return r;
   endfunction

   function automatic logic [RW*MAXP-1:0] widen_route(input logic [MAXP-1:0] m);
      logic [RW*MAXP-1:0] r;
      for (int i = 0; i < MAXP; i++) r[i*RW +: RW] = {RW{m[i]}};
      return r;
   endfunction

   logic [NPIN-1:0] in_sync;

   gir_sync #(.W(NPIN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (gpio_in),
      .q_o   (in_sync)
   );

   logic [NUM_PORTS-1:0][MAXP-1:0]        dir_all, out_all, ie_all, pol_all, pend_all;
   logic [NUM_PORTS-1:0][TRIG_W*MAXP-1:0] trig_all;
   logic [NUM_PORTS-1:0][RW*MAXP-1:0]     route_all;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [MAXP-1:0]        PM  = pin_mask(p);
      localparam logic [TRIG_W*MAXP-1:0] TM  = widen_trig(PM);
      localparam logic [RW*MAXP-1:0]     RM  = widen_route(PM);

      logic [MAXP-1:0]        dir_r, out_r, ie_r, pol_r, clr_w;
      logic [TRIG_W*MAXP-1:0] trig_r;
      logic [RW*MAXP-1:0]     route_r;
      logic                   sel_w;

      assign sel_w = bus_wen && (bus_addr[AW-1:3] == PAW'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_r   <= '0;
            out_r   <= '0;
            ie_r    <= '0;
            pol_r   <= '0;
            trig_r  <= '0;
            route_r <= '0;
         end else if (sel_w) begin
            case (reg_off_e'(bus_addr[2:0]))
               OFF_DIR:   dir_r   <= bus_wdata[MAXP-1:0] & PM;
               OFF_OUT:   out_r   <= bus_wdata[MAXP-1:0] & PM;
               OFF_IE:    ie_r    <= bus_wdata[MAXP-1:0] & PM;
               OFF_POL:   pol_r   <= bus_wdata[MAXP-1:0] & PM;
               OFF_TRIG:  trig_r  <= bus_wdata[TRIG_W*MAXP-1:0] & TM;
               OFF_ROUTE: route_r <= bus_wdata[RW*MAXP-1:0] & RM;
               default: ;
            endcase
         end
      end

      assign clr_w = (sel_w && (reg_off_e'(bus_addr[2:0]) == OFF_STAT))
                   ? (bus_wdata[MAXP-1:0] & PM) : '0;

      gir_pin_detect #(.MAXP(MAXP), .NPINS(int'(PORT_PINS[p*4 +: 4]))) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .sync_i (in_sync[p*MAXP +: MAXP]),
         .pol_i  (pol_r),
         .trig_i (trig_r),
         .clr_i  (clr_w),
         .pend_o (pend_all[p])
      );

      assign dir_all[p]   = dir_r;
      assign out_all[p]   = out_r;
      assign ie_all[p]    = ie_r;
      assign pol_all[p]   = pol_r;
      assign trig_all[p]  = trig_r;
      assign route_all[p] = route_r;
   end

   logic [NUM_OUTS-1:0][NPIN-1:0] hit;
   logic [NPIN-1:0]               ie_flat;

   assign ie_flat = ie_all;

   gir_route #(.NPIN(NPIN), .NOUT(NUM_OUTS), .RW(RW)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend_all),
      .ie_i    (ie_flat),
      .route_i (route_all),
      .hit_o   (hit),
      .irq_o   (irq)
   );

   assign gpio_oe  = dir_all;
   assign gpio_out = out_all;

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (bus_addr[AW-1:3] == PAW'(p)) begin
            case (reg_off_e'(bus_addr[2:0]))
               OFF_DIR:   bus_rdata[MAXP-1:0]        = dir_all[p];
               OFF_OUT:   bus_rdata[MAXP-1:0]        = out_all[p];
               OFF_IN:    bus_rdata[MAXP-1:0]        = in_sync[p*MAXP +: MAXP] & pin_mask(p);
               OFF_IE:    bus_rdata[MAXP-1:0]        = ie_all[p];
               OFF_POL:   bus_rdata[MAXP-1:0]        = pol_all[p];
               OFF_TRIG:  bus_rdata[TRIG_W*MAXP-1:0] = trig_all[p];
               OFF_ROUTE: bus_rdata[RW*MAXP-1:0]     = route_all[p];
               OFF_STAT:  bus_rdata[MAXP-1:0]        = pend_all[p];
               default: ;
            endcase
         end
      end
      for (int o = 0; o < NUM_OUTS; o++) begin
         if (bus_addr == AW'(OUT_BASE + o)) bus_rdata[NPIN-1:0] = hit[o];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_flat == '0) |=> (irq == '0)); // R9
endmodule

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
   localparam int NUM_PORTS = 2;
   localparam int MAXP      = 8;
   localparam int NUM_OUTS  = 4;
   localparam int DW        = 32;
   localparam int AW        = 6;
   localparam int NPIN      = NUM_PORTS * MAXP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_wen = 1'b0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic [NPIN-1:0] gpio_in = '0;
   logic [NPIN-1:0] gpio_out, gpio_oe;
   logic [NUM_OUTS-1:0] irq;

   int checks = 0;
   int errors = 0;

   logic [7:0]  ie0 = '0, pol0 = '0;
   logic [31:0] trig0 = '0;
   logic [15:0] route0 = '0;

   always #2 clk = ~clk;

   gpio_irq_router #(.NUM_PORTS(NUM_PORTS), .MAXP(MAXP), .PORT_PINS(8'h58),
                     .NUM_OUTS(NUM_OUTS), .DW(DW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_addr  = AW'(addr);
      bus_wdata = data;
      bus_wen   = 1'b1;
      @(negedge clk);
      bus_wen   = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      bus_addr = AW'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic cfg0();
      wr(4, 32'(pol0));
      wr(5, trig0);
      wr(6, 32'(route0));
      wr(3, 32'(ie0));
      tick(2);
   endtask

   task automatic arm(input int pin, input logic [3:0] tr, input int outn);
      trig0[pin*4 +: 4]  = tr;
      route0[pin*2 +: 2] = 2'(outn);
      ie0[pin]           = 1'b1;
      cfg0();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(0, d);  check("R1 dir after reset", d, 0);
      rd(5, d);  check("R1 trig after reset", d, 0);
      rd(14, d); check("R1 port1 route after reset", d, 0);
      check("R1 irq after reset", 32'(irq), 0);
      check("R1 oe after reset", 32'(gpio_oe), 0);
      check("R1 out after reset", 32'(gpio_out), 0);
   endtask

   task automatic t_dir_out();
      wr(0, 32'h0F);
      wr(1, 32'h05);
      tick(1);
      check("R2 gpio_oe", 32'(gpio_oe), 32'h0F);
      check("R2 gpio_out", 32'(gpio_out), 32'h05);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      gpio_in = 16'hFFA5;
      tick(3);
      rd(2, d);  check("R3 port0 input readback", d, 32'hA5);
      rd(10, d); check("R4 port1 readback masked", d, 32'h1F);
      gpio_in = '0;
      tick(5);
   endtask

   task automatic t_unimpl();
      logic [31:0] d;
      wr(8, 32'hFF);
      wr(9, 32'hFF);
      wr(13, 32'hFFFF_FFFF);
      rd(8, d);  check("R4 port1 dir masked", d, 32'h1F);
      rd(13, d); check("R4 port1 trig masked", d, 32'h000F_FFFF);
      tick(1);
      check("R4 port1 oe masked", 32'(gpio_oe[15:8]), 32'h1F);
      check("R4 port1 out masked", 32'(gpio_out[15:8]), 32'h1F);
      wr(13, 0);
      wr(8, 0);
      wr(9, 0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      arm(0, 4'h1, 0);
      gpio_in[0] = 1'b1;
      tick(5);
      check("R5 rise raises irq0", 32'(irq), 32'h1);
      rd(7, d); check("R5 rise status bit0", d, 32'h1);
      gpio_in[0] = 1'b0;
      tick(5);
      check("R5 rise sticky after pin drops", 32'(irq), 32'h1);
      wr(7, 32'h1);
      tick(2);
      check("R8 clear drops irq0", 32'(irq), 0);
      rd(7, d); check("R8 clear status bit0", d, 0);
   endtask

   task automatic t_fall();
      gpio_in[1] = 1'b1;
      tick(5);
      arm(1, 4'h2, 1);
      check("R5 no fall yet", 32'(irq), 0);
      gpio_in[1] = 1'b0;
      tick(5);
      check("R7 fall routed to irq1 only", 32'(irq), 32'h2);
      wr(7, 32'h2);
      tick(2);
      check("R8 fall cleared", 32'(irq), 0);
   endtask

   task automatic t_high();
      arm(2, 4'h4, 2);
      gpio_in[2] = 1'b1;
      tick(5);
      check("R6 high level on irq2", 32'(irq), 32'h4);
      gpio_in[2] = 1'b0;
      tick(5);
      check("R6 high level released", 32'(irq), 0);
   endtask

   task automatic t_low();
      gpio_in[3] = 1'b1;
      tick(5);
      arm(3, 4'h8, 3);
      check("R6 low level idle", 32'(irq), 0);
      gpio_in[3] = 1'b0;
      tick(5);
      check("R6 low level on irq3", 32'(irq), 32'h8);
      gpio_in[3] = 1'b1;
      tick(5);
      check("R6 low level released", 32'(irq), 0);
   endtask

   task automatic t_pol();
      logic [31:0] d;
      gpio_in[4] = 1'b1;
      tick(5);
      pol0[4] = 1'b1;
      arm(4, 4'h4, 2);
      check("R10 inverted high pin quiet", 32'(irq), 0);
      gpio_in[4] = 1'b0;
      tick(5);
      check("R10 inverted low pin fires irq2", 32'(irq), 32'h4);
      rd(7, d); check("R10 status bit4", d, 32'h10);
      gpio_in[4] = 1'b1;
      tick(5);
      check("R10 inverted released", 32'(irq), 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      trig0[5*4 +: 4] = 4'h1;
      cfg0();
      gpio_in[5] = 1'b1;
      tick(5);
      check("R9 disabled pin silent", 32'(irq), 0);
      rd(7, d);  check("R9 raw status still set", d, 32'h20);
      rd(16, d); check("R11 out0 word empty while disabled", d, 0);
      ie0[5] = 1'b1;
      cfg0();
      check("R9 enabled pin fires irq0", 32'(irq), 32'h1);
      rd(16, d); check("R11 out0 word bit5", d, 32'h20);
      rd(17, d); check("R11 out1 word empty", d, 0);
   endtask

   task automatic t_shared();
      logic [31:0] d;
      wr(13, 32'h1);
      wr(14, 32'h0);
      wr(11, 32'h1);
      gpio_in[8] = 1'b1;
      tick(5);
      rd(16, d); check("R11 out0 word two pins", d, 32'h120);
      wr(7, 32'h20);
      tick(2);
      check("R8 irq0 held by other pin", 32'(irq), 32'h1);
      wr(15, 32'h1);
      tick(2);
      check("R8 irq0 drops after last clear", 32'(irq), 0);
      rd(16, d); check("R11 out0 word empty after clears", d, 0);
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_dir_out();
      t_readback();
      t_unimpl();
      t_rise();
      t_fall();
      t_high();
      t_low();
      t_pol();
      t_enable();
      t_shared();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule